// File: doc/BRIEF.md
# ECC Check-Bit Error Injector

This block sits between memory arrays and their consumers so that error-detection logic can be exercised on purpose. It serves three access streams: words being refilled into a cache SRAM (32-bit data, 7 check bits), reads from the main flash array (64-bit data, 8 check bits) and reads from the work flash array (32-bit data, 7 check bits). A single 32-bit control word, written by software through a small register write port, holds a target word address and a replacement check-bit value.

Each stream has its own enable input. When a stream presents a valid access whose word address equals the programmed target and its enable is high, the block puts the programmed check bits on that stream's output in place of the check bits that came in. On the refill stream this value is then written into the cache with the data. On the two flash streams only the returned value changes and the array is not touched. Each stream compares a different slice of its byte address: bits 25:2 for the cache refill, bits 26:3 for main flash and bits 24:2 for work flash. The substitution is purely combinational, and data bits always pass through unchanged.

Top module: `ecc_parity_injector`

## Requirements
- R1: While reset is asserted and after reset releases, the control word read back on `cfg_rdata` is 32'h0.
- R2: A write with `cfg_we` high and `cfg_addr` equal to the parameter `CFG_OFFSET` (default 8'h10) loads `cfg_wdata` into the control word at the next rising clock edge. A write to any other `cfg_addr` leaves the control word unchanged.
- R3: Control word bits 23:0 hold the target word address and bits 31:24 hold the replacement check bits. Each stream takes its check bits from the low end of bits 31:24.
- R4: On the cache refill stream, when `rf_valid` and `rf_inj_en` are high and `rf_addr[25:2]` equals control bits 23:0, `rf_chk_o` equals control bits 30:24. Byte-address bits outside 25:2 do not affect the match.
- R5: On the main flash stream, when `mr_valid` and `mr_inj_en` are high and `mr_addr[26:3]` equals control bits 23:0, `mr_chk_o` equals control bits 31:24. Byte-address bits outside 26:3 do not affect the match.
- R6: On the work flash stream, when `wr_valid` and `wr_inj_en` are high and `wr_addr[24:2]` equals control bits 22:0, `wr_chk_o` equals control bits 30:24. Control bit 23 and byte-address bits outside 24:2 do not affect the match.
- R7: When a stream's valid or enable is low, or its address does not match, its check-bit output equals its check-bit input in the same cycle. Each stream's enable affects only that stream.
- R8: Every data output equals its data input at all times, whether or not injection occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Current control word |
| rf_valid | input | 1 | Cache refill word valid |
| rf_inj_en | input | 1 | Cache refill injection enable |
| rf_addr | input | 32 | Cache refill byte address |
| rf_data_i | input | 32 | Cache refill data in |
| rf_chk_i | input | 7 | Cache refill check bits in |
| rf_data_o | output | 32 | Cache refill data out |
| rf_chk_o | output | 7 | Cache refill check bits out |
| mr_valid | input | 1 | Main flash read valid |
| mr_inj_en | input | 1 | Main flash injection enable |
| mr_addr | input | 32 | Main flash byte address |
| mr_data_i | input | 64 | Main flash read data in |
| mr_chk_i | input | 8 | Main flash check bits in |
| mr_data_o | output | 64 | Main flash read data out |
| mr_chk_o | output | 8 | Main flash check bits out |
| wr_valid | input | 1 | Work flash read valid |
| wr_inj_en | input | 1 | Work flash injection enable |
| wr_addr | input | 32 | Work flash byte address |
| wr_data_i | input | 32 | Work flash read data in |
| wr_chk_i | input | 7 | Work flash check bits in |
| wr_data_o | output | 32 | Work flash data out |
| wr_chk_o | output | 7 | Work flash check bits out |

## Verification
Random accesses are mixed with accesses whose address is built from the programmed target and carries random bits outside the compared slice. This separates the correct bit slice for each stream from a neighbouring slice, such as 25:2 against 26:3. Random valid and enable values show that substitution happens only when all three conditions hold, and only on the stream concerned. Directed cases flip address bits just outside each slice, set control bit 23 for the work flash stream, and write to an unmatched register address. Each of these separates a correct compare width or decode from one that is off by a single bit.

// File: rtl/ecc_inj_pkg.sv
`timescale 1ns/1ps
package ecc_inj_pkg;
    parameter int TGT_W = 24;
    parameter int PAR_W = 8;
    parameter int CTL_W = TGT_W + PAR_W;

    // parity sits above the target so the packed word is {parity, target}
    typedef struct packed {
        logic [PAR_W-1:0] parity;
        logic [TGT_W-1:0] target;
    } inj_ctl_t;
endpackage

// File: rtl/ecc_inj_ctl_reg.sv
`timescale 1ns/1ps
module ecc_inj_ctl_reg
    import ecc_inj_pkg::*;
#(
    parameter int                  CFG_ADDR_W = 8,
    parameter logic [CFG_ADDR_W-1:0] CFG_OFFSET = 8'h10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [CTL_W-1:0]      cfg_wdata,
    output inj_ctl_t              ctl_o
);
    typedef struct packed {
        inj_ctl_t ctl;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we && (cfg_addr == CFG_OFFSET)) begin
            st_d.ctl = inj_ctl_t'(cfg_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_o = st_q.ctl;
endmodule

// File: rtl/ecc_inj_path.sv
`timescale 1ns/1ps
module ecc_inj_path
    import ecc_inj_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int CHK_W   = 7,
    parameter int CMP_LSB = 2,
    parameter int CMP_W   = 24
) (
    input  logic              acc_valid,
    input  logic              acc_en,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_data,
    input  logic [CHK_W-1:0]  acc_chk,
    input  inj_ctl_t          ctl_i,
    output logic [DATA_W-1:0] data_o,
    output logic [CHK_W-1:0]  chk_o
);
    localparam int CMP_MSB = CMP_LSB + CMP_W - 1;

    typedef struct packed {
        logic              hit;
        logic [CHK_W-1:0]  chk;
        logic [DATA_W-1:0] data;
    } path_out_t;

    path_out_t po_d;

    // whole vectors marked so slices left out of the compare raise no warning
    logic [ADDR_W-1:0] unused_addr;
    inj_ctl_t          unused_ctl;
    assign unused_addr = acc_addr;
    assign unused_ctl  = ctl_i;

    always_comb begin
        po_d.hit  = acc_valid && acc_en &&
                    (acc_addr[CMP_MSB:CMP_LSB] == ctl_i.target[CMP_W-1:0]);
        po_d.data = acc_data;
        po_d.chk  = po_d.hit ? ctl_i.parity[CHK_W-1:0] : acc_chk;
    end

    assign data_o = po_d.data;
    assign chk_o  = po_d.chk;
endmodule

// File: rtl/ecc_parity_injector.sv
`timescale 1ns/1ps
module ecc_parity_injector
    import ecc_inj_pkg::*;
#(
    parameter int                    CFG_ADDR_W = 8,
    parameter logic [CFG_ADDR_W-1:0] CFG_OFFSET = 8'h10,
    parameter int                    ADDR_W     = 32,
    parameter int                    NARROW_W   = 32,
    parameter int                    WIDE_W     = 64,
    parameter int                    NARROW_CHK = 7,
    parameter int                    WIDE_CHK   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [31:0]           cfg_wdata,
    output logic [31:0]           cfg_rdata,
    input  logic                  rf_valid,
    input  logic                  rf_inj_en,
    input  logic [ADDR_W-1:0]     rf_addr,
    input  logic [NARROW_W-1:0]   rf_data_i,
    input  logic [NARROW_CHK-1:0] rf_chk_i,
    output logic [NARROW_W-1:0]   rf_data_o,
    output logic [NARROW_CHK-1:0] rf_chk_o,
    input  logic                  mr_valid,
    input  logic                  mr_inj_en,
    input  logic [ADDR_W-1:0]     mr_addr,
    input  logic [WIDE_W-1:0]     mr_data_i,
    input  logic [WIDE_CHK-1:0]   mr_chk_i,
    output logic [WIDE_W-1:0]     mr_data_o,
    output logic [WIDE_CHK-1:0]   mr_chk_o,
    input  logic                  wr_valid,
    input  logic                  wr_inj_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [NARROW_W-1:0]   wr_data_i,
    input  logic [NARROW_CHK-1:0] wr_chk_i,
    output logic [NARROW_W-1:0]   wr_data_o,
    output logic [NARROW_CHK-1:0] wr_chk_o
);
    // word-offset bits below each compared slice
    localparam int NARROW_LSB = $clog2(NARROW_W / 8);
    localparam int WIDE_LSB   = $clog2(WIDE_W / 8);

    inj_ctl_t ctl;

    ecc_inj_ctl_reg #(
        .CFG_ADDR_W (CFG_ADDR_W),
        .CFG_OFFSET (CFG_OFFSET)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ctl_o     (ctl)
    );

    assign cfg_rdata = ctl;

    // cache refill: 24-bit word index
    ecc_inj_path #(
        .ADDR_W (ADDR_W), .DATA_W (NARROW_W), .CHK_W (NARROW_CHK),
        .CMP_LSB (NARROW_LSB), .CMP_W (TGT_W)
    ) u_refill (
        .acc_valid (rf_valid), .acc_en (rf_inj_en), .acc_addr (rf_addr),
        .acc_data (rf_data_i), .acc_chk (rf_chk_i), .ctl_i (ctl),
        .data_o (rf_data_o), .chk_o (rf_chk_o)
    );

    // main flash read: 24-bit index of 64-bit words
    ecc_inj_path #(
        .ADDR_W (ADDR_W), .DATA_W (WIDE_W), .CHK_W (WIDE_CHK),
        .CMP_LSB (WIDE_LSB), .CMP_W (TGT_W)
    ) u_main (
        .acc_valid (mr_valid), .acc_en (mr_inj_en), .acc_addr (mr_addr),
        .acc_data (mr_data_i), .acc_chk (mr_chk_i), .ctl_i (ctl),
        .data_o (mr_data_o), .chk_o (mr_chk_o)
    );

    // work flash read: 23-bit index, top target bit ignored
    ecc_inj_path #(
        .ADDR_W (ADDR_W), .DATA_W (NARROW_W), .CHK_W (NARROW_CHK),
        .CMP_LSB (NARROW_LSB), .CMP_W (TGT_W - 1)
    ) u_work (
        .acc_valid (wr_valid), .acc_en (wr_inj_en), .acc_addr (wr_addr),
        .acc_data (wr_data_i), .acc_chk (wr_chk_i), .ctl_i (ctl),
        .data_o (wr_data_o), .chk_o (wr_chk_o)
    );
endmodule

// File: rtl/ecc_inj_checks.sv
`timescale 1ns/1ps
module ecc_inj_checks #(
    parameter int                    CFG_ADDR_W = 8,
    parameter logic [CFG_ADDR_W-1:0] CFG_OFFSET = 8'h10,
    parameter int                    ADDR_W     = 32,
    parameter int                    NARROW_W   = 32,
    parameter int                    WIDE_W     = 64,
    parameter int                    NARROW_CHK = 7,
    parameter int                    WIDE_CHK   = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_we,
    input logic [CFG_ADDR_W-1:0] cfg_addr,
    input logic [31:0]           cfg_wdata,
    input logic [31:0]           cfg_rdata,
    input logic                  rf_valid,
    input logic                  rf_inj_en,
    input logic [ADDR_W-1:0]     rf_addr,
    input logic [NARROW_W-1:0]   rf_data_i,
    input logic [NARROW_CHK-1:0] rf_chk_i,
    input logic [NARROW_W-1:0]   rf_data_o,
    input logic [NARROW_CHK-1:0] rf_chk_o,
    input logic                  mr_valid,
    input logic                  mr_inj_en,
    input logic [ADDR_W-1:0]     mr_addr,
    input logic [WIDE_W-1:0]     mr_data_i,
    input logic [WIDE_CHK-1:0]   mr_chk_i,
    input logic [WIDE_W-1:0]     mr_data_o,
    input logic [WIDE_CHK-1:0]   mr_chk_o,
    input logic                  wr_valid,
    input logic                  wr_inj_en,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [NARROW_W-1:0]   wr_data_i,
    input logic [NARROW_CHK-1:0] wr_chk_i,
    input logic [NARROW_W-1:0]   wr_data_o,
    input logic [NARROW_CHK-1:0] wr_chk_o
);
    logic cfg_hit, rf_match, mr_match, wr_match;
    assign cfg_hit  = cfg_we && (cfg_addr == CFG_OFFSET);
    assign rf_match = rf_valid && rf_inj_en && (rf_addr[25:2] == cfg_rdata[23:0]);
    assign mr_match = mr_valid && mr_inj_en && (mr_addr[26:3] == cfg_rdata[23:0]);
    assign wr_match = wr_valid && wr_inj_en && (wr_addr[24:2] == cfg_rdata[22:0]);

    p_write_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hit |=> cfg_rdata == $past(cfg_wdata));
    p_write_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_hit |=> $stable(cfg_rdata));
    p_rf_inject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_match |-> rf_chk_o == cfg_rdata[30:24]);
    p_mr_inject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mr_match |-> mr_chk_o == cfg_rdata[31:24]);
    p_wr_inject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_match |-> wr_chk_o == cfg_rdata[30:24]);
    p_rf_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_match |-> rf_chk_o == rf_chk_i);
    p_mr_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_match |-> mr_chk_o == mr_chk_i);
    p_wr_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_match |-> wr_chk_o == wr_chk_i);
    p_data_same_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_data_o == rf_data_i) && (mr_data_o == mr_data_i) && (wr_data_o == wr_data_i));
endmodule

bind ecc_parity_injector ecc_inj_checks #(
    .CFG_ADDR_W (CFG_ADDR_W), .CFG_OFFSET (CFG_OFFSET), .ADDR_W (ADDR_W),
    .NARROW_W (NARROW_W), .WIDE_W (WIDE_W),
    .NARROW_CHK (NARROW_CHK), .WIDE_CHK (WIDE_CHK)
) u_checks (.*);

// File: tb/ecc_parity_injector_test.sv
`timescale 1ns/1ps
module ecc_parity_injector_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        rf_valid = 1'b0, rf_inj_en = 1'b0;
    logic [31:0] rf_addr = '0, rf_data_i = '0, rf_data_o;
    logic [6:0]  rf_chk_i = '0, rf_chk_o;
    logic        mr_valid = 1'b0, mr_inj_en = 1'b0;
    logic [31:0] mr_addr = '0;
    logic [63:0] mr_data_i = '0, mr_data_o;
    logic [7:0]  mr_chk_i = '0, mr_chk_o;
    logic        wr_valid = 1'b0, wr_inj_en = 1'b0;
    logic [31:0] wr_addr = '0, wr_data_i = '0, wr_data_o;
    logic [6:0]  wr_chk_i = '0, wr_chk_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] ctl_model = '0;

    always #5 clk = ~clk;

    ecc_parity_injector uut (.*);

    function automatic logic [6:0] exp_rf(logic [31:0] a, logic v, logic e, logic [6:0] c, logic [31:0] w);
        return (v && e && a[25:2] == w[23:0]) ? w[30:24] : c;
    endfunction
    function automatic logic [7:0] exp_mr(logic [31:0] a, logic v, logic e, logic [7:0] c, logic [31:0] w);
        return (v && e && a[26:3] == w[23:0]) ? w[31:24] : c;
    endfunction
    function automatic logic [6:0] exp_wr(logic [31:0] a, logic v, logic e, logic [6:0] c, logic [31:0] w);
        return (v && e && a[24:2] == w[22:0]) ? w[30:24] : c;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic reg_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a == 8'h10) ctl_model = d;
    endtask

    task automatic check_paths(string tag);
        #1;
        check({tag, " R4/R7 rf_chk"}, 64'(rf_chk_o), 64'(exp_rf(rf_addr, rf_valid, rf_inj_en, rf_chk_i, ctl_model)));
        check({tag, " R5/R7 mr_chk"}, 64'(mr_chk_o), 64'(exp_mr(mr_addr, mr_valid, mr_inj_en, mr_chk_i, ctl_model)));
        check({tag, " R6/R7 wr_chk"}, 64'(wr_chk_o), 64'(exp_wr(wr_addr, wr_valid, wr_inj_en, wr_chk_i, ctl_model)));
        check({tag, " R8 data"}, {rf_data_o ^ rf_data_i, wr_data_o ^ wr_data_i} | (mr_data_o ^ mr_data_i), 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset value in reset", 64'(cfg_rdata), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset value after release", 64'(cfg_rdata), 64'h0);

        // R2 R3: write and field layout
        reg_write(8'h10, 32'hA512_3456);
        check("R2 write loads word", 64'(cfg_rdata), 64'hA512_3456);
        reg_write(8'h14, 32'h0BAD_F00D);
        check("R2 other offset ignored", 64'(cfg_rdata), 64'hA512_3456);

        @(negedge clk);
        rf_valid = 1; rf_inj_en = 1; rf_addr = {6'b0, 24'h123456, 2'b11}; rf_chk_i = 7'h11;
        mr_valid = 1; mr_inj_en = 1; mr_addr = {5'b0, 24'h123456, 3'b101}; mr_chk_i = 8'h11;
        wr_valid = 1; wr_inj_en = 1; wr_addr = {7'b0, 23'h123456, 2'b01}; wr_chk_i = 7'h11;
        #1;
        check("R3 R4 cache parity low bits", 64'(rf_chk_o), 64'h25);
        check("R3 R5 main parity all bits", 64'(mr_chk_o), 64'hA5);
        check("R3 R6 work parity low bits", 64'(wr_chk_o), 64'h25);

        // R4: bit 26 sits outside the cache slice; R5: bit 2 outside the main slice
        @(negedge clk);
        rf_addr[26] = 1'b1; rf_addr[31] = 1'b1;
        mr_addr[2] = 1'b0; mr_addr[27] = 1'b1;
        #1;
        check("R4 bits outside 25:2 ignored", 64'(rf_chk_o), 64'h25);
        check("R5 bits outside 26:3 ignored", 64'(mr_chk_o), 64'hA5);
        @(negedge clk);
        rf_addr[2] = ~rf_addr[2];
        mr_addr[3] = ~mr_addr[3];
        #1;
        check("R7 cache lowest slice bit mismatch", 64'(rf_chk_o), 64'h11);
        check("R7 main lowest slice bit mismatch", 64'(mr_chk_o), 64'h11);

        // R6: target bit 23 set, work compares only 22:0; address bit 25 ignored
        reg_write(8'h10, 32'h3CC0_0042);
        @(negedge clk);
        wr_addr = {6'b0, 1'b1, 23'h400042, 2'b10};
        #1;
        check("R6 target bit 23 ignored", 64'(wr_chk_o), 64'h3C);
        @(negedge clk);
        wr_valid = 1'b0;
        #1;
        check("R7 valid low passes", 64'(wr_chk_o), 64'h11);
        @(negedge clk);
        wr_valid = 1'b1; wr_inj_en = 1'b0;
        #1;
        check("R7 enable low passes", 64'(wr_chk_o), 64'h11);

        // random mix
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 8) == 0) begin
                reg_write(($urandom % 4 == 0) ? 8'(16 + 4 * ($urandom % 3)) : 8'h10, $urandom);
            end
            @(negedge clk);
            rf_valid = 1'($urandom); rf_inj_en = 1'($urandom % 4 != 0);
            mr_valid = 1'($urandom); mr_inj_en = 1'($urandom % 4 != 0);
            wr_valid = 1'($urandom); wr_inj_en = 1'($urandom % 4 != 0);
            rf_addr = $urandom; mr_addr = $urandom; wr_addr = $urandom;
            if ($urandom % 2 == 0) rf_addr[25:2] = ctl_model[23:0];
            if ($urandom % 2 == 0) mr_addr[26:3] = ctl_model[23:0];
            if ($urandom % 2 == 0) wr_addr[24:2] = ctl_model[22:0];
            rf_data_i = $urandom; wr_data_i = $urandom; mr_data_i = {$urandom, $urandom};
            rf_chk_i = 7'($urandom); mr_chk_i = 8'($urandom); wr_chk_i = 7'($urandom);
            check_paths("random");
            check("R2 readback model", 64'(cfg_rdata), 64'(ctl_model));
        end
        summary();
    end
endmodule